// File: doc/BRIEF.md
# ADC Conversion Cycle Controller

This block sequences a converter that produces each result with no pipeline latency. After power comes up it holds everything cleared for a fixed number of cycles and then starts a conversion by itself. A conversion that has begun always runs to completion. Only a loss of power-good stops it. When it finishes, the converter is powered down and the result is latched into a static register. The reference either stays on (rest with the reference alive) or is switched off too (deep rest), depending on the sleep configuration bit.

The block leaves the rest state only when the serial slave reports a valid address acknowledge. That acknowledge also powers the reference back up. A new conversion starts when the slave reports either that the full 16-bit result has been shifted out or that a stop ended the data phase. In slow mode the conversion lasts for several modulator completion pulses, and the calibration request is raised for the whole of it. A result-valid flag marks any conversion that began before the reference had been on long enough to settle.

Top module: `adc_cycle_ctrl`

## Requirements
- R1: After `rst_n` is released, or after `pwr_good` returns high, the block holds `busy`, `conv_pwr` and `ref_pwr` low for exactly POR_CYC clock cycles. On the next cycle a conversion starts with `busy`, `conv_pwr` and `ref_pwr` all high.
- R2: While a conversion runs, `busy` and `conv_pwr` stay high. `addr_ack`, `rd_done` and `bus_stop` have no effect on them.
- R3: A conversion ends on the first `mod_done` pulse when `cfg_slow` was 0 at its start, and on the SLOW_MUL-th pulse when it was 1. In the cycle after the ending pulse, `res_latch` is high for exactly one cycle and `busy` and `conv_pwr` are low.
- R4: At the end of a conversion, `ref_pwr` stays high if `cfg_sleep` is 0 and drops low if `cfg_sleep` is 1.
- R5: In the rest state the block waits and ignores `rd_done`. An `addr_ack` moves it to the data phase and sets `ref_pwr` high one cycle later.
- R6: In the data phase, either `rd_done` or `bus_stop` starts a new conversion, and `busy` is high one cycle later.
- R7: When `res_latch` pulses, `res_valid` is 0 if the conversion started fewer than REF_SETTLE_CYC cycles after `ref_pwr` rose, and 1 if it started more than REF_SETTLE_CYC cycles after. The first conversion after any power-on hold is always invalid.
- R8: `cal_req` is high for the whole of a conversion that started with `cfg_slow` = 1, and low during a conversion that started with `cfg_slow` = 0.
- R9: `pwr_good` low in any state aborts the current activity. One cycle later `busy`, `ref_pwr` and `res_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply good; low acts as a synchronous power-on reset |
| addr_ack | input | 1 | Pulse: slave acknowledged a valid address |
| rd_done | input | 1 | Pulse: all 16 result bits shifted out |
| bus_stop | input | 1 | Pulse: stop condition ended the data phase |
| cfg_slow | input | 1 | Slow mode with calibration (sampled at conversion start) |
| cfg_sleep | input | 1 | Power down the reference after the next conversion |
| mod_done | input | 1 | Pulse: modulator finished one pass |
| conv_pwr | output | 1 | Converter power enable |
| ref_pwr | output | 1 | Reference power enable |
| busy | output | 1 | Conversion in progress (slave NAKs while high) |
| cal_req | output | 1 | Background offset calibration request |
| res_latch | output | 1 | One-cycle strobe to capture the result |
| res_valid | output | 1 | Latched result was taken with a settled reference |

## Verification
The hardest case to reach is a wake from deep rest where the next conversion starts before the reference has settled. This needs a sequence in which one conversion runs with `cfg_sleep` set and the following wake-and-read happens within a few cycles. The stimulus table orders its entries so that each entry's expected valid flag follows from the previous entry's sleep bit and its own wait length. A brownout in the middle of a conversion is driven separately, and the first result after the hold is then checked to be invalid.

// File: rtl/adc_cycle_pkg.sv
package adc_cycle_pkg;
   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_CONV = 2'd1,
      ST_REST = 2'd2,
      ST_XFER = 2'd3
   } cyc_state_e;
endpackage

// File: rtl/adc_por_timer.sv
module adc_por_timer #(
   parameter int POR_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);
   localparam int CW = (POR_CYC > 1) ? $clog2(POR_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(POR_CYC - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || expire_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = run_i && (cnt_q == LAST);

   // R1: the hold window cannot end in the cycle that it starts
   a_r1_no_early_expire: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !$past(run_i) && POR_CYC > 1) |-> !expire_o);
endmodule

// File: rtl/adc_ref_ctrl.sv
module adc_ref_ctrl #(
   parameter int REF_SETTLE_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on_i,
   input  logic off_i,
   output logic ref_pwr_o,
   output logic ready_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ref_pwr_o <= 1'b0;
      else if (off_i)
         ref_pwr_o <= 1'b0;
      else if (on_i)
         ref_pwr_o <= 1'b1;
   end

   generate
      if (REF_SETTLE_CYC == 0) begin : g_instant
         assign ready_o = ref_pwr_o;
      end else begin : g_settle
         localparam int SW = $clog2(REF_SETTLE_CYC + 1);
         localparam logic [SW-1:0] SMAX = SW'(REF_SETTLE_CYC);
         logic [SW-1:0] settle_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               settle_q <= '0;
            else if (!ref_pwr_o)
               settle_q <= '0;
            else if (settle_q != SMAX)
               settle_q <= settle_q + 1'b1;
         end

         assign ready_o = ref_pwr_o && (settle_q == SMAX);

         // R7: a freshly enabled reference is never reported as settled
         a_r7_not_ready_at_wake: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ref_pwr_o) |-> !ready_o);
      end
   endgenerate

   // R5: a wake request without a concurrent power-off turns the reference on
   a_r5_wake_on: assert property (@(posedge clk) disable iff (!rst_n)
      (on_i && !off_i) |=> ref_pwr_o);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_cycle_pkg::*;
#(
   parameter int SLOW_MUL = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic addr_ack,
   input  logic rd_done,
   input  logic bus_stop,
   input  logic cfg_slow,
   input  logic cfg_sleep,
   input  logic mod_done,
   input  logic por_expire_i,
   input  logic ref_ready_i,
   output logic hold_o,
   output logic ref_on_o,
   output logic ref_off_o,
   output logic busy_o,
   output logic cal_req_o,
   output logic res_latch_o,
   output logic res_valid_o
);
   localparam int DW = $clog2(SLOW_MUL + 1);
   localparam logic [DW-1:0] SLOW_LAST = DW'(SLOW_MUL - 1);

   cyc_state_e    state_q;
   logic          slow_q;
   logic          ok_q;
   logic [DW-1:0] done_cnt_q;
   logic [DW-1:0] need_last;
   logic          finish;
   logic          xfer_end;
   logic          hold_go;

   assign need_last = slow_q ? SLOW_LAST : '0;
   assign finish    = (state_q == ST_CONV) && mod_done && (done_cnt_q == need_last);
   assign xfer_end  = (state_q == ST_XFER) && (rd_done || bus_stop);
   assign hold_go   = (state_q == ST_HOLD) && por_expire_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_HOLD;
         slow_q      <= 1'b0;
         ok_q        <= 1'b0;
         done_cnt_q  <= '0;
         res_latch_o <= 1'b0;
         res_valid_o <= 1'b0;
      end else if (!pwr_good) begin
         state_q     <= ST_HOLD;
         slow_q      <= 1'b0;
         ok_q        <= 1'b0;
         done_cnt_q  <= '0;
         res_latch_o <= 1'b0;
         res_valid_o <= 1'b0;
      end else begin
         res_latch_o <= finish;
         unique case (state_q)
            ST_HOLD: begin
               if (por_expire_i) begin
                  state_q    <= ST_CONV;
                  slow_q     <= cfg_slow;
                  ok_q       <= ref_ready_i;
                  done_cnt_q <= '0;
               end
            end
            ST_CONV: begin
               if (finish) begin
                  state_q     <= ST_REST;
                  res_valid_o <= ok_q;
                  done_cnt_q  <= '0;
               end else if (mod_done) begin
                  done_cnt_q <= done_cnt_q + 1'b1;
               end
            end
            ST_REST: begin
               if (addr_ack)
                  state_q <= ST_XFER;
            end
            ST_XFER: begin
               if (xfer_end) begin
                  state_q    <= ST_CONV;
                  slow_q     <= cfg_slow;
                  ok_q       <= ref_ready_i;
                  done_cnt_q <= '0;
               end
            end
            default: state_q <= ST_HOLD;
         endcase
      end
   end

   assign hold_o    = (state_q == ST_HOLD) && pwr_good;
   assign busy_o    = (state_q == ST_CONV);
   assign cal_req_o = busy_o && slow_q;
   assign ref_on_o  = pwr_good && (hold_go || ((state_q == ST_REST) && addr_ack));
   assign ref_off_o = !pwr_good || ((state_q == ST_HOLD) && !por_expire_i)
                      || (finish && cfg_sleep);

   // R2: a running conversion continues until the modulator reports completion
   a_r2_no_abort: assert property (@(posedge clk) disable iff (!rst_n || !pwr_good)
      (busy_o && !mod_done) |=> busy_o);

   // R3: the capture strobe lasts a single cycle and arrives with the converter idle
   a_r3_latch_single: assert property (@(posedge clk) disable iff (!rst_n || !pwr_good)
      res_latch_o |=> !res_latch_o);
   a_r3_latch_idle: assert property (@(posedge clk) disable iff (!rst_n || !pwr_good)
      res_latch_o |-> !busy_o);

   // R5: the rest state is left only on an address acknowledge
   a_r5_rest_waits: assert property (@(posedge clk) disable iff (!rst_n || !pwr_good)
      ((state_q == ST_REST) && !addr_ack) |=> (state_q == ST_REST));

   // R8: the calibration request does not change during a conversion
   a_r8_cal_steady: assert property (@(posedge clk) disable iff (!rst_n || !pwr_good)
      (busy_o && $past(busy_o)) |-> (cal_req_o == $past(cal_req_o)));

   // R9: a brownout clears activity and the valid flag
   a_r9_brownout: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (!busy_o && !res_valid_o));
endmodule

// File: rtl/adc_cycle_ctrl.sv
module adc_cycle_ctrl #(
   parameter int POR_CYC        = 8,
   parameter int REF_SETTLE_CYC = 20,
   parameter int SLOW_MUL       = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic addr_ack,
   input  logic rd_done,
   input  logic bus_stop,
   input  logic cfg_slow,
   input  logic cfg_sleep,
   input  logic mod_done,
   output logic conv_pwr,
   output logic ref_pwr,
   output logic busy,
   output logic cal_req,
   output logic res_latch,
   output logic res_valid
);
   generate
      if (POR_CYC < 1) begin : g_bad_por
         $error("POR_CYC must be at least 1");
      end
      if (SLOW_MUL < 2) begin : g_bad_mul
         $error("SLOW_MUL must be at least 2");
      end
      if (REF_SETTLE_CYC < 0) begin : g_bad_settle
         $error("REF_SETTLE_CYC must not be negative");
      end
   endgenerate

   logic hold_run;
   logic por_expire;
   logic ref_on;
   logic ref_off;
   logic ref_ready;

   adc_por_timer #(.POR_CYC(POR_CYC)) u_por (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (hold_run),
      .expire_o (por_expire)
   );

   adc_ref_ctrl #(.REF_SETTLE_CYC(REF_SETTLE_CYC)) u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_i      (ref_on),
      .off_i     (ref_off),
      .ref_pwr_o (ref_pwr),
      .ready_o   (ref_ready)
   );

   adc_conv_seq #(.SLOW_MUL(SLOW_MUL)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwr_good     (pwr_good),
      .addr_ack     (addr_ack),
      .rd_done      (rd_done),
      .bus_stop     (bus_stop),
      .cfg_slow     (cfg_slow),
      .cfg_sleep    (cfg_sleep),
      .mod_done     (mod_done),
      .por_expire_i (por_expire),
      .ref_ready_i  (ref_ready),
      .hold_o       (hold_run),
      .ref_on_o     (ref_on),
      .ref_off_o    (ref_off),
      .busy_o       (busy),
      .cal_req_o    (cal_req),
      .res_latch_o  (res_latch),
      .res_valid_o  (res_valid)
   );

   assign conv_pwr = busy;

   // R4: the reference follows the sleep bit at the end of a conversion
   a_r4_sleep_ref_off: assert property (@(posedge clk) disable iff (!rst_n || !pwr_good)
      (res_latch && $past(cfg_sleep)) |-> !ref_pwr);
   a_r4_nap_ref_on: assert property (@(posedge clk) disable iff (!rst_n || !pwr_good)
      (res_latch && !$past(cfg_sleep)) |-> ref_pwr);
endmodule

// File: tb/adc_cycle_ctrl_tb.sv
module adc_cycle_ctrl_tb;
   localparam int P_POR    = 8;
   localparam int P_SETTLE = 20;
   localparam int P_MUL    = 2;
   localparam int NVEC     = 7;
   // fields: [6] slow [5] sleep [4] long wait [3] use stop [2] exp cal [1] exp ref [0] exp valid
   localparam logic [6:0] VEC [NVEC] = '{
      7'b0000011, 7'b1101101, 7'b0000010, 7'b0101001,
      7'b1010111, 7'b1100101, 7'b0001010 };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b1;
   logic cfg_slow = 1'b0;
   logic cfg_sleep = 1'b0;
   logic [3:0] ev = 4'b0;   // 0 ack, 1 read done, 2 stop, 3 modulator done
   logic conv_pwr, ref_pwr, busy, cal_req, res_latch, res_valid;
   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   adc_cycle_ctrl #(.POR_CYC(P_POR), .REF_SETTLE_CYC(P_SETTLE), .SLOW_MUL(P_MUL)) u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .addr_ack(ev[0]), .rd_done(ev[1]), .bus_stop(ev[2]),
      .cfg_slow(cfg_slow), .cfg_sleep(cfg_sleep), .mod_done(ev[3]),
      .conv_pwr(conv_pwr), .ref_pwr(ref_pwr), .busy(busy), .cal_req(cal_req),
      .res_latch(res_latch), .res_valid(res_valid));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int b);
      ev[b] = 1'b1;
      @(negedge clk);
      ev[b] = 1'b0;
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      step(3);
      check("R1 reset busy", busy, 1'b0);
      check("R1 reset ref", ref_pwr, 1'b0);
      check("R1 reset valid", res_valid, 1'b0);
      rst_n = 1'b1;
      step(P_POR - 1);
      check("R1 hold busy", busy, 1'b0);
      check("R1 hold ref", ref_pwr, 1'b0);
      step(1);
      check("R1 auto start busy", busy, 1'b1);
      check("R1 auto start conv_pwr", conv_pwr, 1'b1);
      check("R1 auto start ref", ref_pwr, 1'b1);
      step(30);
      pulse(3);
      check("R3 first latch", res_latch, 1'b1);
      check("R7 first result invalid", res_valid, 1'b0);
      check("R4 nap keeps ref", ref_pwr, 1'b1);
      step(2);
      pulse(1);
      check("R5 read ignored in rest", busy, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         logic [6:0] v;
         v = VEC[i];
         cfg_slow  = v[6];
         cfg_sleep = v[5];
         step(10);
         pulse(0);
         check("R5 ack wakes ref", ref_pwr, 1'b1);
         step(v[4] ? 30 : 3);
         pulse(v[3] ? 2 : 1);
         check("R6 conversion restarts", busy, 1'b1);
         check("R8 calibration request", cal_req, v[2]);
         step(3);
         pulse(0);
         pulse(2);
         pulse(1);
         check("R2 bus events ignored", busy, 1'b1);
         check("R2 conv_pwr held", conv_pwr, 1'b1);
         if (v[6]) begin
            pulse(3);
            check("R3 slow needs more passes", busy, 1'b1);
            check("R3 no early latch", res_latch, 1'b0);
            check("R8 cal through conversion", cal_req, 1'b1);
            step(2);
         end
         pulse(3);
         check("R3 latch strobe", res_latch, 1'b1);
         check("R3 converter off", conv_pwr, 1'b0);
         check("R4 reference state", ref_pwr, v[1]);
         check("R7 result valid", res_valid, v[0]);
         step(1);
         check("R3 strobe one cycle", res_latch, 1'b0);
      end

      cfg_slow  = 1'b0;
      cfg_sleep = 1'b0;
      step(5);
      pulse(0);
      step(2);
      pulse(1);
      check("R6 start before brownout", busy, 1'b1);
      step(2);
      pwr_good = 1'b0;
      step(1);
      check("R9 brownout busy", busy, 1'b0);
      check("R9 brownout ref", ref_pwr, 1'b0);
      check("R9 brownout valid", res_valid, 1'b0);
      step(3);
      pwr_good = 1'b1;
      step(P_POR - 1);
      check("R1 post-brownout hold", busy, 1'b0);
      step(1);
      check("R1 post-brownout start", busy, 1'b1);
      step(30);
      pulse(3);
      check("R3 latch after brownout", res_latch, 1'b1);
      check("R7 first after brownout invalid", res_valid, 1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule